// File: doc/BRIEF.md
# Rounding, Clamping and Format Stage for a Filter Output Word

This stage sits behind a low-pass filter's multiply-accumulate core. It takes the wide signed accumulator result and turns it into a 16-bit output word in three steps. First it rounds to a selectable number of significant bits, from 16 down to 9. Second it clamps any overflow to a mode-dependent full-scale limit. Third it can recode the word from two's complement to inverted offset binary.

The accumulator carries `EXTRA_W` fraction bits below output bit 0 and `GUARD_W` headroom bits above output bit 15. Accumulator bit `k + EXTRA_W` therefore has the weight of output bit `k`. The filter's mode decoder supplies `half_gain`. It is high while the filter interpolates with the -6 dB gain that calls for the narrower limit.

The result is captured in an output register whenever `in_valid` is high. An active-low enable stands in for a three-state pad. It gates the word and a drive qualifier without waiting for a clock.

Top module: `out_word_shaper`

## Requirements
- R1: While reset is held, and after its synchronous release until the first `in_valid`, `out_valid` is 0 and the registered word is 0x0000.
- R2: With `rnd_sel` = s (0..7), the kept LSB is output bit s. One is added at the weight just below bit s (for s = 0 that is accumulator bit `EXTRA_W-1`). The result then keeps output bits 15..s, so code 0 gives 16 bits and code 7 gives 9 bits.
- R3: With `half_gain` = 0, a rounded value above 0x7FFF gives 0x7FFF and one below -0x8000 gives 0x8000 (two's complement view).
- R4: With `half_gain` = 1, the limits are 0x3FFF and 0xC000, and values inside them pass unchanged.
- R5: Clamping is applied after rounding, so a rounding carry that pushes a value past full scale is clamped rather than wrapped.
- R6: `fmt_twos` = 1 gives two's complement. `fmt_twos` = 0 gives inverted offset binary: bit 15 is kept and bits 14..0 are inverted. This is applied after clamping, so the clamped values become 0x0000 and 0xFFFF.
- R7: The output register and the format it holds load only on a clock edge with `in_valid` high and otherwise hold. `out_valid` is `in_valid` delayed by one clock.
- R8: With `oe_n` high, `word_out` reads 0 and `word_drv` is 0, at once and without a clock edge. With `oe_n` low, `word_drv` is 1 and `word_out` shows the register.
- R9: In two's complement, the output bits below the kept LSB are zero unless the word is a clamp value. In offset format those bits read as ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accumulator result is valid this cycle |
| acc_in | input | ACC_W (24) | Signed accumulator result |
| rnd_sel | input | SEL_W (3) | Rounding position select |
| half_gain | input | 1 | Narrow (15-bit) clamp limits |
| fmt_twos | input | 1 | 1 = two's complement, 0 = inverted offset binary |
| oe_n | input | 1 | Active-low output enable, asynchronous |
| word_out | output | OUT_W (16) | Output word, 0 while disabled |
| word_drv | output | 1 | Output would be driven |
| out_valid | output | 1 | Registered word was loaded on the last edge |

## Verification
The assertions assume that `rnd_sel`, `half_gain` and `fmt_twos` are known and belong to the same cycle as the `in_valid` sample they qualify. They also assume `oe_n` is never X once the bench starts driving it. The clamp-range and low-bit properties relate the register to the controls one cycle earlier, so these controls must change only together with a new valid sample. The stimulus meets this by changing every input at the falling edge and applying each vector together with its controls as one valid beat. Idle beats drop `in_valid` and leave the accumulator free to change.

// File: rtl/osf_pkg.sv
package osf_pkg;

  typedef enum logic {
    FMT_OFFS = 1'b0,
    FMT_TWOS = 1'b1
  } out_fmt_e;

endpackage

// File: rtl/osf_round.sv
module osf_round #(
  parameter int ACC_W   = 24,
  parameter int EXTRA_W = 4,
  parameter int SEL_W   = 3,
  localparam int SUM_W  = ACC_W + 1,
  localparam int NSEL   = 1 << SEL_W
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic [SEL_W-1:0]        sel,
  output logic signed [SUM_W-1:0] rounded
);

  logic [SUM_W-1:0] inc_tab  [NSEL];
  logic [SUM_W-1:0] keep_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_pos
    localparam int LSB = g + EXTRA_W;
    assign inc_tab[g]  = SUM_W'(1) << (LSB - 1);
    assign keep_tab[g] = ~((SUM_W'(1) << LSB) - SUM_W'(1));
  end

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum     = {acc[ACC_W-1], acc} + inc_tab[sel];
    rounded = $signed(sum & keep_tab[sel]);
  end

endmodule

// File: rtl/osf_clamp.sv
module osf_clamp #(
  parameter int SUM_W   = 25,
  parameter int EXTRA_W = 4,
  parameter int OUT_W   = 16,
  localparam int V_W    = SUM_W - EXTRA_W,
  localparam int FULL_HI = (1 << (OUT_W - 1)) - 1,
  localparam int HALF_HI = (1 << (OUT_W - 2)) - 1
) (
  input  logic signed [SUM_W-1:0] val,
  input  logic                    half_gain,
  output logic [OUT_W-1:0]        word
);

  logic signed [V_W-1:0] v;
  logic signed [V_W-1:0] hi;
  logic signed [V_W-1:0] lo;

  always_comb begin
    v  = val[SUM_W-1:EXTRA_W];
    hi = half_gain ? V_W'(HALF_HI) : V_W'(FULL_HI);
    lo = ~hi;
    if (v > hi) begin
      word = hi[OUT_W-1:0];
    end else if (v < lo) begin
      word = lo[OUT_W-1:0];
    end else begin
      word = v[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/osf_format.sv
module osf_format #(
  parameter int OUT_W = 16
) (
  input  logic [OUT_W-1:0]      tc_word,
  input  osf_pkg::out_fmt_e     fmt,
  output logic [OUT_W-1:0]      word
);

  always_comb begin
    if (fmt == osf_pkg::FMT_TWOS) begin
      word = tc_word;
    end else begin
      word = {tc_word[OUT_W-1], ~tc_word[OUT_W-2:0]};
    end
  end

endmodule

// File: rtl/out_word_shaper.sv
module out_word_shaper #(
  parameter int OUT_W   = 16,
  parameter int GUARD_W = 4,
  parameter int EXTRA_W = 4,
  parameter int SEL_W   = 3,
  localparam int ACC_W  = OUT_W + GUARD_W + EXTRA_W,
  localparam int SUM_W  = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [SEL_W-1:0] rnd_sel,
  input  logic             half_gain,
  input  logic             fmt_twos,
  input  logic             oe_n,
  output logic [OUT_W-1:0] word_out,
  output logic             word_drv,
  output logic             out_valid
);

  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q = rst_pipe[1];

  // datapath: round, then clamp, then recode
  logic signed [SUM_W-1:0] rnd_val;
  logic [OUT_W-1:0]        clamp_word;
  logic [OUT_W-1:0]        fmt_word;
  osf_pkg::out_fmt_e       fmt_sel;

  assign fmt_sel = fmt_twos ? osf_pkg::FMT_TWOS : osf_pkg::FMT_OFFS;

  osf_round #(
    .ACC_W  (ACC_W),
    .EXTRA_W(EXTRA_W),
    .SEL_W  (SEL_W)
  ) u_round (
    .acc    ($signed(acc_in)),
    .sel    (rnd_sel),
    .rounded(rnd_val)
  );

  osf_clamp #(
    .SUM_W  (SUM_W),
    .EXTRA_W(EXTRA_W),
    .OUT_W  (OUT_W)
  ) u_clamp (
    .val      (rnd_val),
    .half_gain(half_gain),
    .word     (clamp_word)
  );

  osf_format #(
    .OUT_W(OUT_W)
  ) u_format (
    .tc_word(clamp_word),
    .fmt    (fmt_sel),
    .word   (fmt_word)
  );

  // output register with explicit load enable
  logic [OUT_W-1:0] out_q;
  logic [OUT_W-1:0] out_d;
  logic             vld_q;
  logic             vld_d;

  always_comb begin
    out_d = in_valid ? fmt_word : out_q;
    vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign out_valid = vld_q;
  assign word_drv  = ~oe_n;
  assign word_out  = oe_n ? '0 : out_q;

endmodule

// File: rtl/osf_checker.sv
module osf_checker #(
  parameter int OUT_W = 16,
  parameter int SEL_W = 3,
  localparam int TOP_LSB = (1 << SEL_W) - 1,
  localparam logic [OUT_W-1:0] FULL_HI = {1'b0, {(OUT_W-1){1'b1}}},
  localparam logic [OUT_W-1:0] HALF_HI = {2'b00, {(OUT_W-2){1'b1}}}
) (
  input logic             clk,
  input logic             rst_q,
  input logic             in_valid,
  input logic [SEL_W-1:0] rnd_sel,
  input logic             half_gain,
  input logic             fmt_twos,
  input logic             oe_n,
  input logic [OUT_W-1:0] out_q,
  input logic             out_valid,
  input logic [OUT_W-1:0] word_out,
  input logic             word_drv
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(out_q));

  p_vld_up_r7: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  p_vld_dn_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);

  p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && half_gain && fmt_twos) |=>
      ($signed(out_q) <= $signed(HALF_HI) && $signed(out_q) >= $signed(~HALF_HI)));

  p_lowzero_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && fmt_twos && rnd_sel == SEL_W'(TOP_LSB)) |=>
      (out_q[TOP_LSB-1:0] == '0 || out_q == FULL_HI || out_q == HALF_HI));

  always_comb begin
    if (oe_n === 1'b1) begin
      p_oe_off_r8: assert (word_out == '0 && !word_drv);
    end
  end

endmodule

bind out_word_shaper osf_checker #(
  .OUT_W(OUT_W),
  .SEL_W(SEL_W)
) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .in_valid (in_valid),
  .rnd_sel  (rnd_sel),
  .half_gain(half_gain),
  .fmt_twos (fmt_twos),
  .oe_n     (oe_n),
  .out_q    (out_q),
  .out_valid(out_valid),
  .word_out (word_out),
  .word_drv (word_drv)
);

// File: tb/out_word_shaper_test.sv
module out_word_shaper_test;

  localparam int ACC_W = 24;
  localparam int NV    = 18;
  localparam int VW    = 24 + 3 + 1 + 1 + 16 + 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] acc_in;
  logic [2:0]  rnd_sel;
  logic        half_gain;
  logic        fmt_twos;
  logic        oe_n;
  logic [15:0] word_out;
  logic        word_drv;
  logic        out_valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  out_word_shaper uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .acc_in   (acc_in),
    .rnd_sel  (rnd_sel),
    .half_gain(half_gain),
    .fmt_twos (fmt_twos),
    .oe_n     (oe_n),
    .word_out (word_out),
    .word_drv (word_drv),
    .out_valid(out_valid)
  );

  // {acc, rnd_sel, half_gain, fmt_twos, expected word, requirement number}
  localparam logic [VW-1:0] VEC [NV] = '{
    {24'h040180, 3'd0, 1'b0, 1'b1, 16'h4018, 4'd2},  // R2 exact value
    {24'h040180, 3'd0, 1'b0, 1'b0, 16'h3FE7, 4'd6},  // R6 offset format
    {24'h040188, 3'd0, 1'b0, 1'b1, 16'h4019, 4'd2},  // R2 half LSB rounds up
    {24'h040187, 3'd0, 1'b0, 1'b1, 16'h4018, 4'd2},  // R2 below half rounds down
    {24'h040180, 3'd7, 1'b0, 1'b1, 16'h4000, 4'd9},  // R9 9-bit, low bits cleared
    {24'h040400, 3'd7, 1'b0, 1'b1, 16'h4080, 4'd2},  // R2 9-bit rounds up
    {24'h0123C0, 3'd3, 1'b0, 1'b1, 16'h1240, 4'd2},  // R2 mid position
    {24'h080000, 3'd0, 1'b0, 1'b1, 16'h7FFF, 4'd3},  // R3 positive clamp
    {24'hF7FFF0, 3'd0, 1'b0, 1'b1, 16'h8000, 4'd3},  // R3 negative clamp
    {24'h040000, 3'd0, 1'b0, 1'b1, 16'h4000, 4'd4},  // R4 wide mode passes 4000
    {24'h040000, 3'd0, 1'b1, 1'b1, 16'h3FFF, 4'd4},  // R4 narrow positive clamp
    {24'hFBFFF0, 3'd0, 1'b1, 1'b1, 16'hC000, 4'd4},  // R4 narrow negative clamp
    {24'h03FFE0, 3'd0, 1'b1, 1'b1, 16'h3FFE, 4'd4},  // R4 inside narrow range
    {24'h07FFF0, 3'd7, 1'b0, 1'b1, 16'h7FFF, 4'd5},  // R5 rounding carry clamps
    {24'h080000, 3'd0, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 clamp high, offset
    {24'hF7FFF0, 3'd0, 1'b0, 1'b0, 16'hFFFF, 4'd6},  // R6 clamp low, offset
    {24'hFFFFF7, 3'd0, 1'b0, 1'b1, 16'hFFFF, 4'd2},  // R2 negative rounding
    {24'hFC0170, 3'd7, 1'b0, 1'b0, 16'hBFFF, 4'd9}   // R9 offset, low bits ones
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    acc_in    = '0;
    rnd_sel   = '0;
    half_gain = 1'b0;
    fmt_twos  = 1'b1;
    oe_n      = 1'b0;
    repeat (3) @(negedge clk);
    chk(1, word_out, 16'h0000);                 // R1 word in reset
    chk(1, {15'd0, out_valid}, 16'd0);          // R1 valid in reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(1, word_out, 16'h0000);                 // R1 after release
    chk(1, {15'd0, out_valid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      {acc_in, rnd_sel, half_gain, fmt_twos} = VEC[i][VW-1:20];
      in_valid = 1'b1;
      @(negedge clk);
      chk(int'(VEC[i][3:0]), word_out, VEC[i][19:4]);
      chk(7, {15'd0, out_valid}, 16'd1);        // R7 valid follows
    end

    // R7: idle beat with a new accumulator holds the word
    in_valid = 1'b0;
    acc_in   = 24'h012340;
    fmt_twos = 1'b1;
    @(negedge clk);
    chk(7, word_out, 16'hBFFF);
    chk(7, {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    chk(7, word_out, 16'hBFFF);

    // R8: enable acts without a clock edge
    #1 oe_n = 1'b1;
    #1;
    chk(8, word_out, 16'h0000);
    chk(8, {15'd0, word_drv}, 16'd0);
    oe_n = 1'b0;
    #1;
    chk(8, word_out, 16'hBFFF);
    chk(8, {15'd0, word_drv}, 16'd1);

    // R1: reset again mid-run clears the register
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(1, word_out, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule